// File: doc/BRIEF.md
# Processor Status Register with Arithmetic Flags

This block is the eight-bit status register of a small eight-bit processor core. It keeps three arithmetic flags (zero, half carry and carry) and two power-state bits (watchdog expiry indicator and low-power indicator). The flags are derived inside the block from the ALU operands and the operation code the ALU is executing, so the decoder only has to say which flags the current instruction is allowed to change. The block does not return the ALU result itself.

Software may also write the register as an ordinary data location. When the same instruction both writes the register and updates flags, the flag update wins for the whole arithmetic group. The two power-state bits cannot be written by software. Power-up, watchdog clear, sleep entry and watchdog expiry events from the surrounding system move them. Subtraction uses the add-the-complement method, so carry and half carry read 1 when no borrow occurred.

Top module: `status_reg_core`

## Requirements
- R1: The read value has bits 7..5 always 0, bit 4 = TO (watchdog expiry indicator), bit 3 = PD (low-power indicator), bit 2 = Z, bit 1 = DC, bit 0 = C. After power-on reset it reads 8'h18.
- R2: A write (`wr_en_i`=1) while `flag_mask_i` is 3'b000 loads Z, DC and C from `wr_data_i` bits 2, 1 and 0 on the next clock edge.
- R3: Write data bits 7..3 have no effect. TO and PD never change because of a write.
- R4: `flag_mask_i` bit 2 selects Z, bit 1 selects DC and bit 0 selects C. When the mask is nonzero, a write in the same cycle has no effect on any of Z, DC or C. Selected flags take their computed values, and unselected ones keep their values.
- R5: Without a write, a nonzero mask updates only the selected flags, and the other flags hold their values.
- R6: Op codes on `alu_op_i`: 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, 5 rotate left through carry, 6 rotate right through carry, 7 pass a, 8 clear. Codes 9..15 act as pass. The computed Z is 1 exactly when the operation's result is zero.
- R7: For add, C is the carry out of bit 7 and DC is the carry out of bit 3.
- R8: For subtract, C is 1 when a >= b (no borrow) and DC is 1 when a[3:0] >= b[3:0].
- R9: Rotate left gives result {a[6:0], C}, and the new C is a[7]. Rotate right gives result {C, a[7:1]}, and the new C is a[0]. Here C is the carry value held before the operation.
- R10: A clear instruction aimed at the register (op 8, mask 3'b100, write data 0) sets Z, leaves DC and C unchanged and leaves bits 7..5 at 0.
- R11: TO is set by power-up, cleared by watchdog expiry, and otherwise set by watchdog clear or sleep. Priority is power-up first, then watchdog expiry, then clear or sleep.
- R12: PD is set by power-up or watchdog clear and cleared by sleep. Power-up and watchdog clear both win over sleep, and watchdog expiry leaves PD unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| alu_a_i | input | DW | First ALU operand |
| alu_b_i | input | DW | Second ALU operand |
| alu_op_i | input | 4 | ALU operation code |
| flag_mask_i | input | 3 | Flags the current instruction updates {Z, DC, C} |
| wr_en_i | input | 1 | Register write strobe (address matched) |
| wr_data_i | input | 8 | Register write data |
| ev_pwrup_i | input | 1 | Power-up event |
| ev_wdt_clr_i | input | 1 | Watchdog clear instruction event |
| ev_sleep_i | input | 1 | Sleep instruction event |
| ev_wdt_to_i | input | 1 | Watchdog expiry event |
| stat_o | output | 8 | Register read value |

## Verification
On every cycle, the assertions check three things. A plain write loads the flags. A flag update overrides a concurrent write, and unselected flags hold. Each power event drives TO and PD as specified, and writes never move them. The assertions do not check whether the computed flags are arithmetically correct: borrow polarity, half carry on subtraction, and the carry shifted in by the rotates. Only the bench's directed cases and its randomly drawn operand, mask and event mix, compared against an independent model, can show these. The bench also covers the reset value, the constant-zero upper bits and the clear-instruction sequence.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int STAT_W  = 8;
    localparam int OP_W    = 4;
    localparam int MASK_W  = 3;

    localparam int POS_C   = 0;
    localparam int POS_DC  = 1;
    localparam int POS_Z   = 2;
    localparam int POS_PD  = 3;
    localparam int POS_TO  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_IOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_RLF  = 4'd5,
        OP_RRF  = 4'd6,
        OP_PASS = 4'd7,
        OP_CLR  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

    typedef struct packed {
        logic to;
        logic pd;
        logic z;
        logic dc;
        logic c;
    } stat_t;

endpackage

// File: rtl/status_flag_calc.sv
module status_flag_calc
    import status_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            cin_i,
    output flags_t          flags_o
);
    localparam int HALF = DW / 2;

    logic            is_sub;
    logic [DW-1:0]   b_eff;
    logic [DW:0]     full_sum;
    logic [HALF:0]   low_sum;
    logic [DW-1:0]   res;
    logic            c_calc;
    logic            dc_calc;

    // Subtraction adds the inverted operand plus one: carries are inverted borrows.
    always_comb begin
        is_sub   = (alu_op_e'(op_i) == OP_SUB);
        b_eff    = is_sub ? ~b_i : b_i;
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + (DW+1)'(is_sub);
        low_sum  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + (HALF+1)'(is_sub);
    end

    always_comb begin
        res     = a_i;
        c_calc  = 1'b0;
        dc_calc = 1'b0;
        case (alu_op_e'(op_i))
            OP_ADD, OP_SUB: begin
                res     = full_sum[DW-1:0];
                c_calc  = full_sum[DW];
                dc_calc = low_sum[HALF];
            end
            OP_AND:  res = a_i & b_i;
            OP_IOR:  res = a_i | b_i;
            OP_XOR:  res = a_i ^ b_i;
            OP_RLF: begin
                res    = {a_i[DW-2:0], cin_i};
                c_calc = a_i[DW-1];
            end
            OP_RRF: begin
                res    = {cin_i, a_i[DW-1:1]};
                c_calc = a_i[0];
            end
            OP_CLR:  res = '0;
            default: res = a_i;
        endcase
        flags_o.z  = (res == '0);
        flags_o.dc = dc_calc;
        flags_o.c  = c_calc;
    end

endmodule

// File: rtl/status_pwr_next.sv
module status_pwr_next (
    input  logic to_q,
    input  logic pd_q,
    input  logic ev_pwrup_i,
    input  logic ev_wdt_clr_i,
    input  logic ev_sleep_i,
    input  logic ev_wdt_to_i,
    output logic to_d,
    output logic pd_d
);
    always_comb begin
        to_d = to_q;
        pd_d = pd_q;
        if (ev_pwrup_i) begin
            to_d = 1'b1;
            pd_d = 1'b1;
        end else begin
            if (ev_wdt_to_i) begin
                to_d = 1'b0;
            end else if (ev_wdt_clr_i || ev_sleep_i) begin
                to_d = 1'b1;
            end
            if (ev_wdt_clr_i) begin
                pd_d = 1'b1;
            end else if (ev_sleep_i) begin
                pd_d = 1'b0;
            end
        end
    end
endmodule

// File: rtl/status_reg_core.sv
module status_reg_core
    import status_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DW-1:0]     alu_a_i,
    input  logic [DW-1:0]     alu_b_i,
    input  logic [OP_W-1:0]   alu_op_i,
    input  logic [MASK_W-1:0] flag_mask_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              ev_pwrup_i,
    input  logic              ev_wdt_clr_i,
    input  logic              ev_sleep_i,
    input  logic              ev_wdt_to_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam stat_t STAT_POR = '{to: 1'b1, pd: 1'b1, z: 1'b0, dc: 1'b0, c: 1'b0};
    localparam int    PAD_W    = STAT_W - POS_TO - 1;

    stat_t  stat_d, stat_q;
    flags_t calc_flags;
    logic   to_d, pd_d;
    logic   any_event;

    status_flag_calc #(.DW(DW)) u_flags (
        .a_i     (alu_a_i),
        .b_i     (alu_b_i),
        .op_i    (alu_op_i),
        .cin_i   (stat_q.c),
        .flags_o (calc_flags)
    );

    status_pwr_next u_pwr (
        .to_q         (stat_q.to),
        .pd_q         (stat_q.pd),
        .ev_pwrup_i   (ev_pwrup_i),
        .ev_wdt_clr_i (ev_wdt_clr_i),
        .ev_sleep_i   (ev_sleep_i),
        .ev_wdt_to_i  (ev_wdt_to_i),
        .to_d         (to_d),
        .pd_d         (pd_d)
    );

    always_comb begin
        stat_d = stat_q;
        // A plain write reaches the flags only when no flag update is in flight.
        if (wr_en_i && (flag_mask_i == '0)) begin
            stat_d.z  = wr_data_i[POS_Z];
            stat_d.dc = wr_data_i[POS_DC];
            stat_d.c  = wr_data_i[POS_C];
        end
        if (flag_mask_i[POS_Z])  stat_d.z  = calc_flags.z;
        if (flag_mask_i[POS_DC]) stat_d.dc = calc_flags.dc;
        if (flag_mask_i[POS_C])  stat_d.c  = calc_flags.c;
        stat_d.to = to_d;
        stat_d.pd = pd_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= STAT_POR;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o    = {{PAD_W{1'b0}}, stat_q.to, stat_q.pd, stat_q.z, stat_q.dc, stat_q.c};
    assign any_event = ev_pwrup_i | ev_wdt_clr_i | ev_sleep_i | ev_wdt_to_i;

    p_plain_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && flag_mask_i == '0) |=> stat_o[2:0] == $past(wr_data_i[2:0]));

    p_power_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !any_event) |=> $stable(stat_o[POS_TO:POS_PD]));

    p_carry_calc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_mask_i[POS_C] |=> stat_o[POS_C] == $past(calc_flags.c));

    p_zero_calc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_mask_i[POS_Z] |=> stat_o[POS_Z] == $past(calc_flags.z));

    p_dc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_mask_i != '0 && !flag_mask_i[POS_DC]) |=> $stable(stat_o[POS_DC]));

    p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && flag_mask_i == '0) |=> $stable(stat_o[2:0]));

    p_pwrup_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_pwrup_i |=> stat_o[POS_TO:POS_PD] == 2'b11);

    p_expiry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_wdt_to_i && !ev_pwrup_i) |=> !stat_o[POS_TO]);

    p_sleep_pd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_sleep_i && !ev_wdt_clr_i && !ev_pwrup_i) |=> !stat_o[POS_PD]);

endmodule

// File: tb/status_reg_core_tb.sv
module status_reg_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0, b = '0, wdata = '0;
    logic [3:0] op = '0;
    logic [2:0] mask = '0;
    logic       wr = 1'b0;
    logic       e_up = 1'b0, e_clr = 1'b0, e_slp = 1'b0, e_to = 1'b0;
    logic [7:0] stat;

    int n_chk = 0;
    int n_bad = 0;

    logic m_to, m_pd, m_z, m_dc, m_c;

    always #4 clk = ~clk;

    status_reg_core #(.DW(8)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .alu_a_i(a), .alu_b_i(b), .alu_op_i(op),
        .flag_mask_i(mask), .wr_en_i(wr), .wr_data_i(wdata),
        .ev_pwrup_i(e_up), .ev_wdt_clr_i(e_clr), .ev_sleep_i(e_slp), .ev_wdt_to_i(e_to),
        .stat_o(stat)
    );

    // Independent flag model: returns {z, dc, c}
    function automatic logic [2:0] ref_flags(input logic [3:0] o, input logic [7:0] x,
                                             input logic [7:0] y, input logic cin);
        int r; logic fc, fdc;
        fc = 1'b0; fdc = 1'b0; r = x;
        case (o)
            4'd0: begin r = x + y; fc = (r > 255); fdc = ((x % 16) + (y % 16)) > 15; end
            4'd1: begin r = x - y; fc = (x >= y); fdc = ((x % 16) >= (y % 16)); end
            4'd2: r = x & y;
            4'd3: r = x | y;
            4'd4: r = x ^ y;
            4'd5: begin r = (x * 2) + cin; fc = x[7]; end
            4'd6: begin r = (x / 2) + (cin ? 128 : 0); fc = x[0]; end
            4'd8: r = 0;
            default: r = x;
        endcase
        return {((r % 256) == 0), fdc, fc};
    endfunction

    function automatic logic [7:0] model_val();
        return {3'b000, m_to, m_pd, m_z, m_dc, m_c};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic model_step();
        logic [2:0] f;
        f = ref_flags(op, a, b, m_c);
        if (wr && mask == 3'b000) begin
            m_z = wdata[2]; m_dc = wdata[1]; m_c = wdata[0];
        end
        if (mask[2]) m_z  = f[2];
        if (mask[1]) m_dc = f[1];
        if (mask[0]) m_c  = f[0];
        if (e_up) begin
            m_to = 1'b1; m_pd = 1'b1;
        end else begin
            if (e_to) m_to = 1'b0;
            else if (e_clr || e_slp) m_to = 1'b1;
            if (e_clr) m_pd = 1'b1;
            else if (e_slp) m_pd = 1'b0;
        end
    endtask

    // Drive at negedge, register at posedge, sample at the following negedge.
    task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic [2:0] m, input logic w, input logic [7:0] d,
                         input logic [3:0] ev, input string tag);
        op = o; a = x; b = y; mask = m; wr = w; wdata = d;
        {e_up, e_clr, e_slp, e_to} = ev;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, stat, model_val());
    endtask

    task automatic idle();
        op = 4'd7; a = '0; b = '0; mask = '0; wr = 1'b0; wdata = '0;
        {e_up, e_clr, e_slp, e_to} = 4'b0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        m_to = 1'b1; m_pd = 1'b1; m_z = 1'b0; m_dc = 1'b0; m_c = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", stat, 8'h18);

        // R2/R3: plain writes
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b1, 8'hFF, 4'b0000, "R2 R3 write ones");
        check("R3 upper and power bits after write", stat, 8'h1F);
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b1, 8'h00, 4'b0000, "R2 write zeros");
        check("R2 write zeros value", stat, 8'h18);

        // R11/R12: power events
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 4'b0010, "R12 sleep");
        check("R12 sleep clears PD", stat, 8'h10);
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 4'b0001, "R11 expiry");
        check("R11 expiry clears TO", stat, 8'h00);
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b1, 8'hFF, 4'b0000, "R3 write cannot set TO PD");
        check("R3 TO PD stay clear", stat, 8'h07);
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 4'b0100, "R11 R12 wdt clear");
        check("R11 R12 clear sets both", stat, 8'h1F);

        // R7 add
        apply(4'd0, 8'h0F, 8'h01, 3'b111, 1'b0, 8'h00, 4'b0000, "R7 half carry");
        check("R7 add 0F+01", stat, 8'h1A);
        apply(4'd0, 8'hFF, 8'h01, 3'b111, 1'b0, 8'h00, 4'b0000, "R6 R7 wrap");
        check("R6 R7 add FF+01", stat, 8'h1F);

        // R8 subtract
        apply(4'd1, 8'h03, 8'h04, 3'b111, 1'b0, 8'h00, 4'b0000, "R8 borrow");
        check("R8 sub 03-04", stat, 8'h18);
        apply(4'd1, 8'h10, 8'h01, 3'b111, 1'b0, 8'h00, 4'b0000, "R8 nibble borrow");
        check("R8 sub 10-01", stat, 8'h19);
        apply(4'd1, 8'h05, 8'h05, 3'b111, 1'b0, 8'h00, 4'b0000, "R8 equal");
        check("R6 R8 sub 05-05", stat, 8'h1F);

        // R4 priority of flag update over write
        apply(4'd0, 8'h01, 8'h01, 3'b111, 1'b1, 8'hFF, 4'b0000, "R4 update beats write");
        check("R4 computed flags", stat, 8'h18);
        apply(4'd0, 8'h80, 8'h80, 3'b001, 1'b1, 8'hFF, 4'b0000, "R4 partial mask");
        check("R4 unselected flags ignore write", stat, 8'h19);

        // R9 rotates
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b1, 8'h00, 4'b0000, "R2 clear flags");
        apply(4'd5, 8'h80, 8'h00, 3'b101, 1'b0, 8'h00, 4'b0000, "R9 rotate left");
        check("R9 rlf 80 cin0", stat, 8'h1D);
        apply(4'd6, 8'h01, 8'h00, 3'b101, 1'b0, 8'h00, 4'b0000, "R9 rotate right");
        check("R9 rrf 01 cin1", stat, 8'h19);

        // R10 clear instruction on the register
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b1, 8'h03, 4'b0000, "R2 set DC C");
        apply(4'd8, 8'h5A, 8'h00, 3'b100, 1'b1, 8'h00, 4'b0000, "R10 clear register");
        check("R10 clear sets Z keeps DC C", stat, 8'h1F);

        // R5 flag update without write
        apply(4'd2, 8'hF0, 8'h0F, 3'b100, 1'b0, 8'h00, 4'b0000, "R5 and zero");
        apply(4'd4, 8'h5A, 8'h5B, 3'b100, 1'b0, 8'h00, 4'b0000, "R5 xor nonzero");
        check("R5 only Z changes", stat, 8'h1B);

        // R11/R12 priorities
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 4'b1011, "R11 R12 power-up wins");
        check("R11 power-up priority", stat, 8'h1B);
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 4'b0101, "R11 expiry beats clear");
        check("R11 expiry with clear", stat, 8'h0B);
        apply(4'd7, 8'h00, 8'h00, 3'b000, 1'b0, 8'h00, 4'b0110, "R12 clear beats sleep");
        check("R12 clear with sleep", stat, 8'h1B);

        // Random mix
        seed = 32'h5EED_0C0D;
        void'($urandom(seed));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ro;
            logic [3:0] rev;
            ro = 4'($urandom_range(0, 15));
            rev = {($urandom_range(0, 31) == 0), ($urandom_range(0, 15) == 0),
                   ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
            apply(ro, 8'($urandom), 8'($urandom), 3'($urandom), ($urandom_range(0, 3) == 0),
                  8'($urandom), rev, "R4 R6 R7 R8 R9 R11 R12 random");
        end
        idle();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule